// File: doc/BRIEF.md
# Instruction Prefetch Stream Buffer Controller

This controller sits beside an instruction cache and services its misses. It keeps a single stream buffer slot that holds one block fetched ahead of demand. The slot is separate from the cache. When the cache reports a miss, the controller first looks in the slot. If the slot does not hold the block, the controller asks the unified second-level cache for the missed block and then for the block after it. The missed block goes to the cache and the following block is parked in the slot. If the slot does hold the block, the controller moves it into the cache and fetches the next sequential block into the slot.

The cache side sends a one-cycle miss pulse with a block address. It is then stalled until the controller returns one fill beat that carries the block address and data. The lower side has a valid/ready request port that carries block addresses. Its response port returns one data beat per request, in the order the requests were issued. Only one demand miss is in progress at a time. A miss that matches a prefetch still in flight waits for that response instead of requesting the block again. Block addresses wrap modulo 2^ADDR_W.

Top module: `isb_prefetch_ctrl`

## Requirements
- R1: After reset, `stall`, `fill_valid` and `l2_req_valid` are all low.
- R2: On a miss whose block i is not in the stream buffer, the controller issues exactly two lower-level requests. The first is for block i and the second is for block i+1, and block i is always requested first.
- R3: A miss serviced from the lower level produces one fill beat with `fill_blk` = i and `fill_data` equal to the response data for block i.
- R4: A prefetched block is held in the stream buffer and produces no fill beat until a later miss asks for it.
- R5: A miss that matches a stream buffer entry whose data has already arrived issues no lower-level request for that block. Its fill beat carries the buffered data and appears in the cycle after the miss is accepted.
- R6: After a miss to block b is served from the stream buffer, the controller issues one lower-level request for block b+1.
- R7: A miss that matches a stream buffer entry whose prefetch is still outstanding issues no duplicate request. The fill beat follows that prefetch response and carries its data.
- R8: A miss that does not match the stream buffer discards the old entry. A late response for the discarded prefetch never reaches the cache or the buffer. A later miss to the discarded block is fetched from the lower level again.
- R9: `stall` rises in the cycle after a miss is accepted and stays high up to and including the fill beat's cycle. It is low in the cycle after the fill. A miss is accepted only while `stall` is low.
- R10: The block following address 2^ADDR_W-1 is block 0, both for prefetch requests and for stream buffer matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | One-cycle miss pulse from the cache, taken only while `stall` is low |
| miss_blk | input | ADDR_W | Block address of the miss |
| stall | output | 1 | Cache side must hold off new misses |
| fill_valid | output | 1 | One-cycle fill beat toward the cache |
| fill_blk | output | ADDR_W | Block address being filled |
| fill_data | output | DATA_W | Block data being filled |
| l2_req_valid | output | 1 | Request to the lower-level cache is pending |
| l2_req_ready | input | 1 | Lower level accepts the request this cycle |
| l2_req_blk | output | ADDR_W | Block address requested |
| l2_rsp_valid | input | 1 | Response beat, in request order |
| l2_rsp_data | input | DATA_W | Response block data |

## Verification
The assertions watch the stall protocol on every cycle. Each accepted miss raises stall, stall is released only by a fill, and the fill comes the cycle after a ready buffer hit. They also check that a prefetch response always finds a pending buffer slot and that no discarded response is still outstanding when a new miss arrives. The bench scenarios cover several things the assertions cannot see: the order and the absence of lower-level requests, the data carried by each fill, and a discarded prefetch response returning late after a redirect. They also cover the address wrap and a re-fetch of a block whose buffered copy was thrown away.

// File: rtl/isb_pkg.sv
package isb_pkg;
  // Destination of the response beat at the head of the lower-level return stream.
  typedef enum logic [1:0] {
    RSP_NONE     = 2'd0,
    RSP_DROP     = 2'd1,
    RSP_DEMAND   = 2'd2,
    RSP_PREFETCH = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/isb_slot.sv
module isb_slot #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [ADDR_W-1:0] arm_blk,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              vld,
  output logic              pend,
  output logic [ADDR_W-1:0] blk,
  output logic [DATA_W-1:0] data
);
  logic              vld_q, pend_q;
  logic [ADDR_W-1:0] blk_q;
  logic [DATA_W-1:0] data_q;

  // Arming (re)allocates the slot to a new block and wins over a load.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
      blk_q  <= '0;
    end else if (arm) begin
      vld_q  <= 1'b1;
      pend_q <= 1'b1;
      blk_q  <= arm_blk;
    end else if (load) begin
      pend_q <= 1'b0;
    end
  end

  // Data storage carries no reset so it maps to plain registers or RAM.
  always_ff @(posedge clk) begin
    if (load && !arm) data_q <= load_data;
  end

  assign vld  = vld_q;
  assign pend = pend_q;
  assign blk  = blk_q;
  assign data = data_q;

  // R7: a prefetch beat only lands in a slot that is waiting for it.
  p_load_pending_r7: assert property (@(posedge clk) disable iff (rst)
    (load && !arm) |-> (vld_q && pend_q));
endmodule

// File: rtl/isb_issue.sv
module isb_issue #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_dem,
  input  logic [ADDR_W-1:0] dem_blk,
  input  logic              arm_pf,
  input  logic [ADDR_W-1:0] pf_blk,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_blk,
  output logic              dem_sent,
  output logic              pf_sent,
  output logic              pf_queued
);
  logic              need_d, need_p;
  logic [ADDR_W-1:0] d_blk_q, p_blk_q;

  // Demand always goes out ahead of the prefetch.
  assign req_valid = need_d | need_p;
  assign req_blk   = need_d ? d_blk_q : p_blk_q;
  assign dem_sent  = need_d & req_ready;
  assign pf_sent   = ~need_d & need_p & req_ready;
  assign pf_queued = need_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      need_d  <= 1'b0;
      need_p  <= 1'b0;
      d_blk_q <= '0;
      p_blk_q <= '0;
    end else begin
      if (arm_dem) begin
        need_d  <= 1'b1;
        d_blk_q <= dem_blk;
      end else if (dem_sent) begin
        need_d <= 1'b0;
      end
      if (arm_pf) begin
        need_p  <= 1'b1;
        p_blk_q <= pf_blk;
      end else if (pf_sent) begin
        need_p <= 1'b0;
      end
    end
  end

  // R2: a new demand never overwrites one that has not been sent.
  p_no_rearm_dem_r2: assert property (@(posedge clk) disable iff (rst)
    arm_dem |-> !need_d);
endmodule

// File: rtl/isb_prefetch_ctrl.sv
module isb_prefetch_ctrl #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_blk,
  output logic              stall,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_blk,
  output logic [DATA_W-1:0] fill_data,
  output logic              l2_req_valid,
  input  logic              l2_req_ready,
  output logic [ADDR_W-1:0] l2_req_blk,
  input  logic              l2_rsp_valid,
  input  logic [DATA_W-1:0] l2_rsp_data
);
  import isb_pkg::*;

  localparam logic [ADDR_W-1:0] BLK_STEP = ADDR_W'(1);

  logic              busy_q, stale_q, dem_out_q, wait_q;
  logic [ADDR_W-1:0] cur_blk_q;
  logic              fill_valid_q;
  logic [ADDR_W-1:0] fill_blk_q;
  logic [DATA_W-1:0] fill_data_q;

  logic              sb_vld, sb_pend;
  logic [ADDR_W-1:0] sb_blk;
  logic [DATA_W-1:0] sb_data;
  logic              dem_sent, pf_sent, pf_queued;

  rsp_kind_e         rsp_kind;
  logic              accept, sb_match, sb_ready_now, hit_ready, hit_wait, sb_miss;
  logic              wait_fill, arm_pf, pf_rsp, dem_rsp, fill_next;
  logic [ADDR_W-1:0] arm_blk;
  logic [DATA_W-1:0] sb_now_data;

  // Responses come back in issue order: discarded prefetches first, then the
  // demand, then the live prefetch.
  always_comb begin
    if (!l2_rsp_valid)  rsp_kind = RSP_NONE;
    else if (stale_q)   rsp_kind = RSP_DROP;
    else if (dem_out_q) rsp_kind = RSP_DEMAND;
    else                rsp_kind = RSP_PREFETCH;
  end

  assign pf_rsp       = (rsp_kind == RSP_PREFETCH);
  assign dem_rsp      = (rsp_kind == RSP_DEMAND);
  assign accept       = miss_valid & ~busy_q;
  assign sb_match     = sb_vld & (sb_blk == miss_blk);
  assign sb_ready_now = ~sb_pend | pf_rsp;
  assign sb_now_data  = sb_pend ? l2_rsp_data : sb_data;
  assign hit_ready    = accept & sb_match & sb_ready_now;
  assign hit_wait     = accept & sb_match & ~sb_ready_now;
  assign sb_miss      = accept & ~sb_match;
  assign wait_fill    = wait_q & pf_rsp;
  assign arm_pf       = hit_ready | wait_fill | sb_miss;
  assign arm_blk      = (wait_fill ? sb_blk : miss_blk) + BLK_STEP;
  assign fill_next    = hit_ready | wait_fill | dem_rsp;

  isb_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm_pf),
    .arm_blk   (arm_blk),
    .load      (pf_rsp),
    .load_data (l2_rsp_data),
    .vld       (sb_vld),
    .pend      (sb_pend),
    .blk       (sb_blk),
    .data      (sb_data)
  );

  isb_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .arm_dem   (sb_miss),
    .dem_blk   (miss_blk),
    .arm_pf    (arm_pf),
    .pf_blk    (arm_blk),
    .req_ready (l2_req_ready),
    .req_valid (l2_req_valid),
    .req_blk   (l2_req_blk),
    .dem_sent  (dem_sent),
    .pf_sent   (pf_sent),
    .pf_queued (pf_queued)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      stale_q      <= 1'b0;
      dem_out_q    <= 1'b0;
      wait_q       <= 1'b0;
      cur_blk_q    <= '0;
      fill_valid_q <= 1'b0;
    end else begin
      if (accept)            busy_q <= 1'b1;
      else if (fill_valid_q) busy_q <= 1'b0;
      if (accept) cur_blk_q <= miss_blk;
      // A prefetch already sent for an entry being discarded returns later
      // and must be dropped.
      if (sb_miss && sb_vld && sb_pend && !pf_rsp && (!pf_queued || pf_sent))
        stale_q <= 1'b1;
      else if (rsp_kind == RSP_DROP)
        stale_q <= 1'b0;
      if (dem_sent)     dem_out_q <= 1'b1;
      else if (dem_rsp) dem_out_q <= 1'b0;
      if (hit_wait)       wait_q <= 1'b1;
      else if (wait_fill) wait_q <= 1'b0;
      fill_valid_q <= fill_next;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_next) begin
      fill_blk_q  <= hit_ready ? miss_blk : (wait_fill ? sb_blk : cur_blk_q);
      fill_data_q <= hit_ready ? sb_now_data : l2_rsp_data;
    end
  end

  assign stall      = busy_q;
  assign fill_valid = fill_valid_q;
  assign fill_blk   = fill_blk_q;
  assign fill_data  = fill_data_q;

  // R9: stall protocol around each miss.
  p_stall_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> stall);
  p_stall_held_r9: assert property (@(posedge clk) disable iff (rst)
    (stall && !fill_valid) |=> stall);
  p_fill_under_stall_r9: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> stall);
  p_release_after_fill_r9: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !stall);
  // R5: a ready buffer hit fills on the next cycle with the missed block.
  p_ready_hit_fill_r5: assert property (@(posedge clk) disable iff (rst)
    hit_ready |=> (fill_valid && fill_blk == $past(miss_blk)));
  // R8: every discarded response has drained before another miss is taken.
  p_no_stale_at_accept_r8: assert property (@(posedge clk) disable iff (rst)
    accept |-> !stale_q);
  // R4: a prefetch beat always has a pending buffer slot to land in.
  p_pf_rsp_target_r4: assert property (@(posedge clk) disable iff (rst)
    pf_rsp |-> (sb_vld && sb_pend));
endmodule

// File: tb/isb_prefetch_ctrl_tb.sv
module isb_prefetch_ctrl_tb;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int LAT = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          miss_valid = 1'b0;
  logic [AW-1:0] miss_blk = '0;
  logic          stall, fill_valid;
  logic [AW-1:0] fill_blk;
  logic [DW-1:0] fill_data;
  logic          l2_req_valid;
  logic          l2_req_ready = 1'b1;
  logic [AW-1:0] l2_req_blk;
  logic          l2_rsp_valid = 1'b0;
  logic [DW-1:0] l2_rsp_data = '0;

  always #2.5 clk = ~clk;

  isb_prefetch_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_blk(miss_blk),
    .stall(stall), .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_data(fill_data),
    .l2_req_valid(l2_req_valid), .l2_req_ready(l2_req_ready), .l2_req_blk(l2_req_blk),
    .l2_rsp_valid(l2_rsp_valid), .l2_rsp_data(l2_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int fills_seen = 0;
  bit done = 0;
  string tag = "R1";

  logic [AW-1:0] exp_req_q[$];
  logic [AW-1:0] exp_fill_q[$];
  logic [AW-1:0] l2_blk_q[$];
  int            l2_due_q[$];

  function automatic logic [DW-1:0] dfun(logic [AW-1:0] a);
    return {4'hA, a ^ 12'h5A5, a[7:0], 8'h3C};
  endfunction

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // Lower-level model: in-order responses, fixed latency.
  always @(negedge clk) begin
    l2_rsp_valid <= 1'b0;
    if (!rst && l2_req_valid && l2_req_ready) begin
      l2_blk_q.push_back(l2_req_blk);
      l2_due_q.push_back(cyc + LAT);
    end
    if (l2_blk_q.size() > 0 && cyc >= l2_due_q[0]) begin
      l2_rsp_valid <= 1'b1;
      l2_rsp_data  <= dfun(l2_blk_q[0]);
      void'(l2_blk_q.pop_front());
      void'(l2_due_q.pop_front());
    end
  end

  // Monitor: compare requests and fills against the scoreboard queues.
  always @(negedge clk) begin
    if (!rst) begin
      if (l2_req_valid && l2_req_ready) begin
        if (exp_req_q.size() == 0)
          check(0, tag, "unexpected lower-level request", DW'(l2_req_blk), '0);
        else begin
          check(l2_req_blk == exp_req_q[0], tag, "request order (R2/R6)",
                DW'(l2_req_blk), DW'(exp_req_q[0]));
          void'(exp_req_q.pop_front());
        end
      end
      if (fill_valid) begin
        fills_seen++;
        if (exp_fill_q.size() == 0)
          check(0, tag, "unexpected fill (R4)", DW'(fill_blk), '0);
        else begin
          check(fill_blk == exp_fill_q[0], tag, "fill block (R3)",
                DW'(fill_blk), DW'(exp_fill_q[0]));
          check(fill_data == dfun(exp_fill_q[0]), tag, "fill data (R3)",
                fill_data, dfun(exp_fill_q[0]));
          void'(exp_fill_q.pop_front());
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_miss(logic [AW-1:0] b, bit ready_hit);
    while (stall) @(negedge clk);
    exp_fill_q.push_back(b);
    miss_valid = 1'b1;
    miss_blk   = b;
    @(negedge clk);
    miss_valid = 1'b0;
    check(stall == 1'b1, "R9", "stall after accept", DW'(stall), 1);
    if (ready_hit)
      check(fill_valid == 1'b1, "R5", "fill in cycle after ready hit", DW'(fill_valid), 1);
    while (stall) @(negedge clk);
    check(fill_valid == 1'b0, "R9", "stall low only after fill cycle", DW'(fill_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(stall == 0, "R1", "stall after reset", DW'(stall), 0);
    check(fill_valid == 0, "R1", "fill_valid after reset", DW'(fill_valid), 0);
    check(l2_req_valid == 0, "R1", "l2_req_valid after reset", DW'(l2_req_valid), 0);
    rst = 1'b0;
    idle(2);

    // R2 R3: cold miss fetches i then i+1.
    tag = "R2";
    exp_req_q.push_back(12'h010); exp_req_q.push_back(12'h011);
    do_miss(12'h010, 0);
    idle(20);
    check(fills_seen == 1, "R4", "prefetched block not filled", DW'(fills_seen), 1);
    check(exp_req_q.size() == 0, "R2", "both requests issued", DW'(exp_req_q.size()), 0);

    // R5 R6: ready buffer hit, then next block requested.
    tag = "R5";
    exp_req_q.push_back(12'h012);
    do_miss(12'h011, 1);

    // R7: hit on pending prefetch, no duplicate.
    tag = "R7";
    exp_req_q.push_back(12'h013);
    do_miss(12'h012, 0);

    // R8: redirect while 0x013 prefetch is in flight.
    tag = "R8";
    exp_req_q.push_back(12'h040); exp_req_q.push_back(12'h041);
    do_miss(12'h040, 0);
    idle(20);
    tag = "R6";
    exp_req_q.push_back(12'h042);
    do_miss(12'h041, 1);
    idle(20);

    // R10: wrap of the block address.
    tag = "R10";
    exp_req_q.push_back(12'hFFF); exp_req_q.push_back(12'h000);
    do_miss(12'hFFF, 0);
    idle(20);
    exp_req_q.push_back(12'h001);
    do_miss(12'h000, 1);
    idle(20);

    // R8: discarded ready entry must be fetched again.
    tag = "R8";
    exp_req_q.push_back(12'h080); exp_req_q.push_back(12'h081);
    do_miss(12'h080, 0);
    idle(20);
    exp_req_q.push_back(12'h001); exp_req_q.push_back(12'h002);
    do_miss(12'h001, 0);
    idle(20);

    check(exp_req_q.size() == 0, "R2", "all expected requests seen", DW'(exp_req_q.size()), 0);
    check(exp_fill_q.size() == 0, "R3", "all expected fills seen", DW'(exp_fill_q.size()), 0);
    check(fills_seen == 9, "R4", "total fill beats", DW'(fills_seen), 9);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog %s actual=hung expected=finished", tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule